// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block collects a bank of level-sensitive interrupt sources, samples them into a raw level register, and drives a single summary request toward a primary interrupt controller whenever any enabled source is active. A software-raised request can be injected on source 0, so firmware can trigger the summary line without any hardware source.

A fixed window of sources (indices 21 to 30 by default) can also be routed around the summary line. Each source in the window has its own routing enable, and when that enable is set the source level appears on its own bit of a passthrough vector. That vector connects to dedicated inputs of the primary controller. The enable mask, the software request and the routing enables are each changed through a pair of write-only set/clear words, so a write never has to read and modify the register. The register port is word addressed: `wordAddr` is the byte offset divided by four. Reads are combinational from the register state. Writes take effect on the clock edge.

Top module: `sec_irq_ctrl`

## Requirements
- R1: On every clock edge the raw level register captures `srcIn`. A read of word 1 returns the raw levels, with bit 0 also set while the software request is latched.
- R2: `combIrq` is registered. It is high one clock after the bitwise AND of raw levels and enable mask is nonzero, and low one clock after that AND is zero.
- R3: The readable words are: word 0 returns raw AND mask, word 2 returns the enable mask, word 4 returns raw bit 0 in bit 0 with zeros elsewhere, and word 8 returns the routing enables.
- R4: A write to word 2 ORs the write data into the enable mask. A write to word 3 clears each mask bit that is 1 in the data.
- R5: A write of nonzero data to word 4 latches the software request. A nonzero write to word 5 clears it. A zero-data write to either word leaves it unchanged. The latch is ORed into raw bit 0.
- R6: A write to word 8 ORs the data into the routing enables, but only bits 21 through 30 can be set. A write to word 9 clears each enable bit that is 1 in the data.
- R7: For each index from 21 to 30 whose routing enable is set, `passIrq` carries that raw level one clock later. All other `passIrq` bits are 0.
- R8: A read of any word other than 0, 1, 2, 4 or 8 returns zero, and this includes the write-only words 3, 5 and 9. A write to any word other than 2, 3, 4, 5, 8 or 9 changes no state.
- R9: Synchronous active-high `rst` clears the enable mask, the routing enables, the software latch, the raw register and both outputs.
- R10: A source change and a register write in the same cycle both take effect on the same edge. A source 0 falling while the software request is set keeps raw bit 0 high. A window source rising while its routing enable is cleared gives no passthrough pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcIn | input | 32 | Level-sensitive interrupt sources |
| wordAddr | input | 10 | Register word index (byte offset / 4) |
| wrEn | input | 1 | Write strobe for the addressed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed word |
| combIrq | output | 1 | Summary request to the primary controller |
| passIrq | output | 32 | Per-source routed requests (bits 21..30 only) |

## Verification
Two functions can fall on the same edge: a source sample and a register write. The bench provokes the case in two ways. It drops source 0 in the same cycle that it writes the software-set word, and it raises source 22 in the same cycle that it clears that source's routing enable. The first case is judged correct when the raw read still shows bit 0 and `combIrq` stays high. The second is judged correct when `passIrq` stays all zero and the routing enables read back without bit 22.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

  // Word indices of the register port. Decoded values are fixed by behaviour.
  localparam int W_STAT  = 0;
  localparam int W_RAW   = 1;
  localparam int W_ENSET = 2;
  localparam int W_ENCLR = 3;
  localparam int W_SWSET = 4;
  localparam int W_SWCLR = 5;
  localparam int W_PTSET = 8;
  localparam int W_PTCLR = 9;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic softSet;
    logic softClr;
    logic passSet;
    logic passClr;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STAT,
    RD_RAW,
    RD_MASK,
    RD_SOFT,
    RD_PASS
  } rdSel_e;

endpackage

// File: rtl/sec_irq_decode.sv
module sec_irq_decode
  import sec_irq_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32
) (
  input  logic [WORD_W-1:0] wordAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb,
  output rdSel_e            rdSel
);

  logic dataNz;
  assign dataNz = |wrData;

  always_comb begin
    strb  = '0;
    rdSel = RD_ZERO;
    case (wordAddr)
      WORD_W'(W_STAT):  rdSel = RD_STAT;
      WORD_W'(W_RAW):   rdSel = RD_RAW;
      WORD_W'(W_ENSET): begin
        rdSel        = RD_MASK;
        strb.maskSet = wrEn;
      end
      WORD_W'(W_ENCLR): strb.maskClr = wrEn;
      WORD_W'(W_SWSET): begin
        rdSel        = RD_SOFT;
        strb.softSet = wrEn && dataNz;
      end
      WORD_W'(W_SWCLR): strb.softClr = wrEn && dataNz;
      WORD_W'(W_PTSET): begin
        rdSel        = RD_PASS;
        strb.passSet = wrEn;
      end
      WORD_W'(W_PTCLR): strb.passClr = wrEn;
      default: ;
    endcase
  end

endmodule

// File: rtl/sec_irq_datapath.sv
module sec_irq_datapath
  import sec_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strb,
  input  rdSel_e            rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              combIrq,
  output logic [DATA_W-1:0] passIrq,
  output logic [DATA_W-1:0] rawLvl,
  output logic [DATA_W-1:0] enMask,
  output logic [DATA_W-1:0] passEn
);

  logic [DATA_W-1:0] srcReg;
  logic [DATA_W-1:0] winMask;
  logic              softLatch;

  // Routing window: only indices PASS_LO..PASS_HI may be routed.
  for (genvar i = 0; i < DATA_W; i++) begin : g_win
    assign winMask[i] = (i >= PASS_LO) && (i <= PASS_HI);
  end

  assign rawLvl = {srcReg[DATA_W-1:1], srcReg[0] | softLatch};

  always_ff @(posedge clk) begin
    if (rst) begin
      srcReg    <= '0;
      enMask    <= '0;
      passEn    <= '0;
      softLatch <= 1'b0;
      combIrq   <= 1'b0;
      passIrq   <= '0;
    end else begin
      srcReg <= srcIn;
      if (strb.maskSet)      enMask <= enMask | wrData;
      else if (strb.maskClr) enMask <= enMask & ~wrData;
      if (strb.softSet)      softLatch <= 1'b1;
      else if (strb.softClr) softLatch <= 1'b0;
      if (strb.passSet)      passEn <= passEn | (wrData & winMask);
      else if (strb.passClr) passEn <= passEn & ~wrData;
      combIrq <= |(rawLvl & enMask);
      passIrq <= rawLvl & passEn & winMask;
    end
  end

  always_comb begin
    case (rdSel)
      RD_STAT: rdData = rawLvl & enMask;
      RD_RAW:  rdData = rawLvl;
      RD_MASK: rdData = enMask;
      RD_SOFT: rdData = {{(DATA_W-1){1'b0}}, rawLvl[0]};
      RD_PASS: rdData = passEn;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sec_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 10,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [WORD_W-1:0] wordAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              combIrq,
  output logic [DATA_W-1:0] passIrq
);

  strobe_t           strb;
  rdSel_e            rdSel;
  logic [DATA_W-1:0] rawLvl;
  logic [DATA_W-1:0] enMask;
  logic [DATA_W-1:0] passEn;

  sec_irq_decode #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_decode (
    .wordAddr(wordAddr),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  sec_irq_datapath #(.DATA_W(DATA_W), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .srcIn  (srcIn),
    .wrData (wrData),
    .strb   (strb),
    .rdSel  (rdSel),
    .rdData (rdData),
    .combIrq(combIrq),
    .passIrq(passIrq),
    .rawLvl (rawLvl),
    .enMask (enMask),
    .passEn (passEn)
  );

endmodule

// File: rtl/sec_irq_chk.sv
module sec_irq_chk
  import sec_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WORD_W  = 10,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] wordAddr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              combIrq,
  input logic [DATA_W-1:0] passIrq,
  input logic [DATA_W-1:0] rawLvl,
  input logic [DATA_W-1:0] enMask,
  input logic [DATA_W-1:0] passEn
);

  logic [DATA_W-1:0] winChk;
  logic              armed = 1'b0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_win
    assign winChk[i] = (i >= PASS_LO) && (i <= PASS_HI);
  end

  always_ff @(posedge clk) armed <= !rst;

  logic wrMaskSet, wrMaskClr, wrPassClr, wrOther;
  assign wrMaskSet = wrEn && (wordAddr == WORD_W'(W_ENSET));
  assign wrMaskClr = wrEn && (wordAddr == WORD_W'(W_ENCLR));
  assign wrPassClr = wrEn && (wordAddr == WORD_W'(W_PTCLR));
  assign wrOther   = wrEn && !(wordAddr inside {WORD_W'(W_ENSET), WORD_W'(W_ENCLR),
                                                 WORD_W'(W_PTSET), WORD_W'(W_PTCLR)});

  AST_COMB_TRACKS: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |=> combIrq == $past(|(rawLvl & enMask))); // R2
  AST_MASK_OR: assert property (@(posedge clk) disable iff (rst || !armed)
    wrMaskSet |=> enMask == ($past(enMask) | $past(wrData))); // R4
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst || !armed)
    wrMaskClr |=> (enMask & $past(wrData)) == '0); // R4
  AST_PASSEN_WINDOW: assert property (@(posedge clk) disable iff (rst || !armed)
    (passEn & ~winChk) == '0); // R6
  AST_PASSEN_CLEAR: assert property (@(posedge clk) disable iff (rst || !armed)
    wrPassClr |=> (passEn & $past(wrData)) == '0); // R6
  AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |=> passIrq == $past(rawLvl & passEn)); // R7
  AST_PASS_OUTSIDE_LOW: assert property (@(posedge clk) disable iff (rst || !armed)
    (passIrq & ~winChk) == '0); // R7
  AST_UNDEF_WRITE_INERT: assert property (@(posedge clk) disable iff (rst || !armed)
    wrOther |=> $stable(enMask) && $stable(passEn)); // R8

endmodule

bind sec_irq_ctrl sec_irq_chk #(
  .DATA_W(DATA_W), .WORD_W(WORD_W), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wordAddr(wordAddr),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .combIrq (combIrq),
  .passIrq (passIrq),
  .rawLvl  (rawLvl),
  .enMask  (enMask),
  .passEn  (passEn)
);

// File: tb/sec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sec_irq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] srcIn = '0;
  logic [9:0]  wordAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        combIrq;
  logic [31:0] passIrq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sec_irq_ctrl u_sec_irq_ctrl (
    .clk(clk), .rst(rst), .srcIn(srcIn), .wordAddr(wordAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .combIrq(combIrq), .passIrq(passIrq)
  );

  typedef struct packed {
    logic [31:0] src;
    logic        wr;
    logic [9:0]  wAddr;
    logic [31:0] wData;
    logic [9:0]  rAddr;
    logic [31:0] expRd;
    logic        expComb;
    logic [31:0] expPass;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 1'b0, 10'd0,  32'h0,          10'd1,  32'h0000_0010, 1'b0, 32'h0,          4'd1},  // R1
    '{32'h0000_0010, 1'b1, 10'd2,  32'h0000_0030,  10'd0,  32'h0000_0010, 1'b1, 32'h0,          4'd4},  // R4 R3
    '{32'h0000_0010, 1'b1, 10'd3,  32'h0000_0010,  10'd2,  32'h0000_0020, 1'b0, 32'h0,          4'd4},  // R4
    '{32'h0000_0020, 1'b0, 10'd0,  32'h0,          10'd0,  32'h0000_0020, 1'b1, 32'h0,          4'd2},  // R2
    '{32'h0000_0000, 1'b1, 10'd8,  32'hFFFF_FFFF,  10'd8,  32'h7FE0_0000, 1'b0, 32'h0,          4'd6},  // R6
    '{32'h8060_0000, 1'b0, 10'd0,  32'h0,          10'd1,  32'h8060_0000, 1'b0, 32'h0060_0000,  4'd7},  // R7
    '{32'h8060_0000, 1'b1, 10'd9,  32'h0020_0000,  10'd8,  32'h7FC0_0000, 1'b0, 32'h0040_0000,  4'd6},  // R6
    '{32'h0000_0000, 1'b1, 10'd4,  32'h0000_0004,  10'd4,  32'h0000_0001, 1'b0, 32'h0,          4'd5},  // R5
    '{32'h0000_0000, 1'b1, 10'd2,  32'h0000_0001,  10'd0,  32'h0000_0001, 1'b1, 32'h0,          4'd5},  // R5
    '{32'h0000_0000, 1'b1, 10'd5,  32'h0000_0000,  10'd4,  32'h0000_0001, 1'b1, 32'h0,          4'd5},  // R5
    '{32'h0000_0000, 1'b1, 10'd5,  32'h0000_0100,  10'd1,  32'h0000_0000, 1'b0, 32'h0,          4'd5},  // R5
    '{32'h0000_0020, 1'b1, 10'd6,  32'hFFFF_FFFF,  10'd6,  32'h0000_0000, 1'b1, 32'h0,          4'd8},  // R8
    '{32'h0000_0020, 1'b0, 10'd0,  32'h0,          10'd2,  32'h0000_0021, 1'b1, 32'h0,          4'd8},  // R8
    '{32'h0000_0000, 1'b1, 10'd10, 32'hFFFF_FFFF,  10'd3,  32'h0000_0000, 1'b0, 32'h0,          4'd8},  // R8
    '{32'h4000_0000, 1'b0, 10'd0,  32'h0,          10'd8,  32'h7FC0_0000, 1'b0, 32'h4000_0000,  4'd7}   // R7
  };

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    wordAddr = 10'd2; #1;
    check("R9", "mask after reset", rdData, 32'h0);
    wordAddr = 10'd8; #1;
    check("R9", "routing after reset", rdData, 32'h0);
    check("R9", "combIrq after reset", {31'b0, combIrq}, 32'h0);
    check("R9", "passIrq after reset", passIrq, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      @(negedge clk);
      srcIn = VECS[i].src; wrEn = VECS[i].wr;
      wordAddr = VECS[i].wAddr; wrData = VECS[i].wData;
      @(negedge clk);
      wrEn = 1'b0; wordAddr = VECS[i].rAddr;
      @(negedge clk);
      check(tag, $sformatf("vec %0d rdData", i), rdData, VECS[i].expRd);
      check(tag, $sformatf("vec %0d combIrq", i), {31'b0, combIrq}, {31'b0, VECS[i].expComb});
      check(tag, $sformatf("vec %0d passIrq", i), passIrq, VECS[i].expPass);
    end

    // R10: source 0 falls in the same cycle as a software-set write (mask = 0x21)
    @(negedge clk); srcIn = 32'h1;
    @(negedge clk);
    @(negedge clk);
    check("R10", "combIrq from source 0", {31'b0, combIrq}, 32'h1);
    srcIn = 32'h0; wrEn = 1'b1; wordAddr = 10'd4; wrData = 32'h1;
    @(negedge clk); wrEn = 1'b0; wordAddr = 10'd1;
    #1 check("R10", "raw bit0 held by soft", rdData, 32'h1);
    @(negedge clk);
    check("R10", "combIrq held", {31'b0, combIrq}, 32'h1);

    // R10: source 22 rises in the same cycle its routing enable is cleared
    srcIn = 32'h0040_0000; wrEn = 1'b1; wordAddr = 10'd9; wrData = 32'h0040_0000;
    @(negedge clk); wrEn = 1'b0; wordAddr = 10'd8;
    check("R10", "passIrq no pulse (1)", passIrq, 32'h0);
    @(negedge clk);
    check("R10", "passIrq no pulse (2)", passIrq, 32'h0);
    check("R10", "routing after clear", rdData, 32'h7F80_0000);

    // R9: reset in mid-run clears mask, routing and soft latch
    srcIn = 32'h0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wordAddr = 10'd4; #1;
    check("R9", "soft after reset", rdData, 32'h0);
    wordAddr = 10'd2; #1;
    check("R9", "mask after reset", rdData, 32'h0);
    wordAddr = 10'd8; #1;
    check("R9", "routing after reset", rdData, 32'h0);
    check("R9", "combIrq after reset", {31'b0, combIrq}, 32'h0);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

endmodule